// File: doc/BRIEF.md
# Programmable Reference Clock Generator

This block derives a reference clock from one of up to nine free-running source clocks. The chosen source is divided by an even ratio set by a 15-bit half-period field, or passed straight through when that field is zero. A single 32-bit control word sets the source, the ratio, the enable, the pad output-enable and three low-power behaviours: halt in debug, halt in idle and run in sleep. Software reads the same word back with two hardware status flags in it. The first, ACTIVE, says the clock path is still busy. The second says a ratio change has not yet reached the source domain.

The divider runs in the selected source domain. Enable, run permission and ratio-change requests reach it through two-flop synchronizers, and its busy status and acknowledge return the same way. When the block stops, the output completes its current high phase and then parks low. A new ratio takes effect only at the end of a high phase, so no short pulse ever reaches the output. Source changes are refused while ACTIVE is set.

Top module: `refclk_gen`

## Requirements
- R1: After reset every control field, both status flags and the readback are zero, and both `refclk_out` and `refclk_oe` are low.
- R2: With a half-period field D between 1 and 32767, the output period is 2·D source cycles and the high phase is D source cycles.
- R3: With D = 0, the output copies the selected source clock, either after enabling or after a live change to zero.
- R4: The select field (bits 3:0) picks a source: 0 fast RC, 1 PLL output 1, 2 primary oscillator, 3 secondary oscillator, 4 low-power RC, 5 PLL output 3, 6 peripheral clock, 7 system clock, 8 external input. A write of a code from 9 to 15 leaves the previous selection in place.
- R5: While ACTIVE (bit 8) reads 1, a write leaves the select field unchanged but still updates the other fields.
- R6: A write is ignored as a whole while the enable bit (bit 15) differs from ACTIVE.
- R7: ACTIVE rises after the enable is set. After the enable is cleared, ACTIVE falls only once the output has parked low. While both read 0, the output is low.
- R8: A write that changes the divisor field (bits 30:16) sets the switch flag (bit 9). The flag clears once the new value is in use. Divisor writes made while the flag is set are ignored.
- R9: While a ratio change is in progress, no output high or low phase is shorter than the shorter half-period of the old and new settings.
- R10: In sleep, the output stops when run-in-sleep (bit 11) is 0 and keeps running when it is 1. Select codes 0 and 1 stop in sleep whatever bit 11 holds.
- R11: When its mode indicator is high, idle-stop (bit 13) stops the output and debug-freeze (bit 14) stops the output. With the control bit at 0, the output keeps running in that mode.
- R12: `refclk_oe` follows the output-enable bit (bit 12).
- R13: The readback places the fields at the bit positions given above, and bits 31, 10 and 7:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-port clock |
| rst_n | input | 1 | Active-low asynchronous reset, all domains |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word readback, including status |
| src_clk | input | NSRC | Candidate source clocks, indexed by select code |
| dbg_mode | input | 1 | Device is in debug halt |
| idle_mode | input | 1 | Device is in idle |
| sleep_mode | input | 1 | Device is in sleep |
| refclk_out | output | 1 | Generated reference clock |
| refclk_oe | output | 1 | Pad output-enable for the reference clock |

## Verification
A ratio reload and an output edge happen together by design, because the new divisor is loaded at the same source edge that ends a high phase. The bench provokes this by changing the divisor while the output is running and then, while the switch flag is still set, writing a second and shorter divisor. A width monitor records every output phase during the changeover. The run is judged on three points: the shortest phase, the final period and the value read back from the divisor field. A live change from a divided setting to bypass repeats this with the output-stage multiplexer moving at the same edge.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
   localparam int DIV_W   = 15;
   localparam int SEL_W   = 4;
   localparam int DIV_LSB = 16;
   localparam int B_ON    = 15;
   localparam int B_FRZ   = 14;
   localparam int B_SIDL  = 13;
   localparam int B_OE    = 12;
   localparam int B_RSLP  = 11;
   localparam int B_DIVSW = 9;
   localparam int B_ACT   = 8;
   // select codes at or below this value cannot run in sleep
   localparam logic [SEL_W-1:0] SEL_NOSLEEP_LAST = 4'd1;

   typedef struct packed {
      logic [DIV_W-1:0] div;
      logic             on;
      logic             frz;
      logic             sidl;
      logic             oe;
      logic             rslp;
      logic [SEL_W-1:0] sel;
   } ctl_t;
endpackage

// File: rtl/refclk_sync.sv
module refclk_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("refclk_sync needs at least two stages");
   end

   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[i] <= '0;
            else        st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/refclk_div.sv
module refclk_div #(
   parameter int DIV_W       = 15,
   parameter int SYNC_STAGES = 2
) (
   input  logic             sclk,
   input  logic             rst_n,
   input  logic             run_a,
   input  logic             on_a,
   input  logic             req_a,
   input  logic [DIV_W-1:0] div_new,
   output logic             clk_o,
   output logic             active_o,
   output logic             ack_o
);
   logic [2:0]       s;
   logic             run, on_s, req_s;
   logic [DIV_W-1:0] div_cur, cnt;
   logic             phase_q, ack_q, gate_n, byp_n;
   logic             bypass, term, load_pt;

   refclk_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(sclk), .rst_n(rst_n), .d({run_a, on_a, req_a}), .q(s));

   assign run     = s[2];
   assign on_s    = s[1];
   assign req_s   = s[0];
   assign bypass  = (div_cur == '0);
   assign term    = (cnt == div_cur - DIV_W'(1));
   // safe reload points: pass-through, parked low, end of a high phase
   assign load_pt = bypass || (!phase_q && !run) || (phase_q && term);

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         div_cur <= '0;
         cnt     <= '0;
         phase_q <= 1'b0;
         ack_q   <= 1'b0;
      end else begin
         if (bypass) begin
            cnt     <= '0;
            phase_q <= 1'b0;
         end else if (phase_q) begin
            if (term) begin
               phase_q <= 1'b0;
               cnt     <= '0;
            end else begin
               cnt <= cnt + DIV_W'(1);
            end
         end else if (!run) begin
            cnt <= '0;
         end else if (term) begin
            phase_q <= 1'b1;
            cnt     <= '0;
         end else begin
            cnt <= cnt + DIV_W'(1);
         end
         if (load_pt && (req_s != ack_q)) begin
            div_cur <= div_new;
            ack_q   <= req_s;
         end
      end
   end

   // pass-through gate and output-stage select move only while sclk is low
   always_ff @(negedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         byp_n  <= 1'b1;
         gate_n <= 1'b0;
      end else begin
         byp_n  <= bypass;
         gate_n <= bypass && run;
      end
   end

   assign clk_o    = byp_n ? (sclk & gate_n) : phase_q;
   assign active_o = on_s | run | phase_q | gate_n;
   assign ack_o    = ack_q;
endmodule

// File: rtl/refclk_regs.sv
module refclk_regs
   import refclk_pkg::*;
#(
   parameter int NSRC = 9
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [31:0] wdata,
   input  logic        active_b,
   input  logic        ack_b,
   input  logic        dbg_i,
   input  logic        idle_i,
   input  logic        sleep_i,
   output ctl_t        ctl_o,
   output logic        req_o,
   output logic        divsw_o,
   output logic        en_o,
   output logic [31:0] rdata
);
   if (NSRC < 1 || NSRC > (1 << SEL_W)) begin : g_bad_nsrc
      $error("refclk_regs: NSRC out of range for select field");
   end

   ctl_t             ctl_q;
   logic             req_q, en_q;
   logic             wr_ok, sel_ok, div_ok;
   logic [DIV_W-1:0] wdiv;
   logic [SEL_W-1:0] wsel;
   logic             unused_wbits;

   assign unused_wbits = ^{wdata[31], wdata[10:4]};
   assign wdiv    = wdata[DIV_LSB +: DIV_W];
   assign wsel    = wdata[SEL_W-1:0];
   assign divsw_o = req_q ^ ack_b;
   assign wr_ok   = we && (ctl_q.on == active_b);
   assign sel_ok  = !active_b && (int'(wsel) < NSRC);
   assign div_ok  = !divsw_o && (wdiv != ctl_q.div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         req_q <= 1'b0;
         en_q  <= 1'b0;
      end else begin
         if (wr_ok) begin
            ctl_q.on   <= wdata[B_ON];
            ctl_q.frz  <= wdata[B_FRZ];
            ctl_q.sidl <= wdata[B_SIDL];
            ctl_q.oe   <= wdata[B_OE];
            ctl_q.rslp <= wdata[B_RSLP];
            if (sel_ok) ctl_q.sel <= wsel;
            if (div_ok) begin
               ctl_q.div <= wdiv;
               req_q     <= ~req_q;
            end
         end
         en_q <= ctl_q.on
               && !(ctl_q.frz && dbg_i)
               && !(ctl_q.sidl && idle_i)
               && !(sleep_i && (!ctl_q.rslp || ctl_q.sel <= SEL_NOSLEEP_LAST));
      end
   end

   always_comb begin
      rdata                      = '0;
      rdata[DIV_LSB +: DIV_W]    = ctl_q.div;
      rdata[B_ON]                = ctl_q.on;
      rdata[B_FRZ]               = ctl_q.frz;
      rdata[B_SIDL]              = ctl_q.sidl;
      rdata[B_OE]                = ctl_q.oe;
      rdata[B_RSLP]              = ctl_q.rslp;
      rdata[B_DIVSW]             = divsw_o;
      rdata[B_ACT]               = active_b;
      rdata[SEL_W-1:0]           = ctl_q.sel;
   end

   assign ctl_o = ctl_q;
   assign req_o = req_q;
   assign en_o  = en_q;
endmodule

// File: rtl/refclk_gen.sv
module refclk_gen
   import refclk_pkg::*;
#(
   parameter int NSRC        = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   input  logic [NSRC-1:0] src_clk,
   input  logic            dbg_mode,
   input  logic            idle_mode,
   input  logic            sleep_mode,
   output logic            refclk_out,
   output logic            refclk_oe
);
   ctl_t ctl;
   logic req, divsw, en;
   logic active_src, ack_src, active_b, ack_b;
   logic sclk;
   logic [1:0] back;

   refclk_regs #(.NSRC(NSRC)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
      .active_b(active_b), .ack_b(ack_b),
      .dbg_i(dbg_mode), .idle_i(idle_mode), .sleep_i(sleep_mode),
      .ctl_o(ctl), .req_o(req), .divsw_o(divsw), .en_o(en), .rdata(reg_rdata));

   // only changed while the source-domain logic is parked
   assign sclk = src_clk[ctl.sel];

   refclk_div #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_div (
      .sclk(sclk), .rst_n(rst_n), .run_a(en), .on_a(ctl.on), .req_a(req),
      .div_new(ctl.div), .clk_o(refclk_out), .active_o(active_src), .ack_o(ack_src));

   refclk_sync #(.W(2), .STAGES(SYNC_STAGES)) u_back (
      .clk(clk), .rst_n(rst_n), .d({active_src, ack_src}), .q(back));

   assign active_b  = back[1];
   assign ack_b     = back[0];
   assign refclk_oe = ctl.oe;
endmodule

// File: rtl/refclk_gen_chk.sv
module refclk_gen_chk #(
   parameter int NSRC = 9
) (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_we,
   input logic [31:0] reg_wdata,
   input logic        on_q,
   input logic [3:0]  sel_q,
   input logic [14:0] div_q,
   input logic        divsw,
   input logic        active_b,
   input logic        refclk_out
);
   logic unused_chk;
   assign unused_chk = ^{reg_wdata[31], reg_wdata[15:4]};

   // R6: enable and status disagree, so nothing may change
   a_r6_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (on_q != active_b) |=> ($stable(on_q) && $stable(sel_q) && $stable(div_q)));

   // R5: select locked while busy
   a_r5_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
      active_b |=> $stable(sel_q));

   // R4: reserved codes never taken
   a_r4_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && (int'(reg_wdata[3:0]) >= NSRC)) |=> $stable(sel_q));

   // R8: divisor frozen while a switch is pending
   a_r8_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
      divsw |=> $stable(div_q));

   // R8: an accepted new divisor raises the switch flag
   a_r8_divsw_set: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && (on_q == active_b) && !divsw && (reg_wdata[30:16] != div_q)) |=> divsw);

   // R7: disabled and idle means the output is parked low
   a_r7_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!on_q && !active_b) |-> !refclk_out);
endmodule

bind refclk_gen refclk_gen_chk #(.NSRC(NSRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
   .on_q(ctl.on), .sel_q(ctl.sel), .div_q(ctl.div), .divsw(divsw),
   .active_b(active_b), .refclk_out(refclk_out));

// File: tb/refclk_gen_bench.sv
`timescale 1ns/1ps
module refclk_gen_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC       = 9;

   logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   wire  [NSRC-1:0] src_clk;
   logic dbg = 1'b0, idle = 1'b0, sleep = 1'b0;
   logic refclk_out, refclk_oe;
   int n_tests = 0, n_fail = 0;
   int edges = 0;
   bit mon_en = 1'b0;
   longint min_w;
   longint last_t;
   int mon_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   // source k has period 6+2k ns
   for (genvar k = 0; k < NSRC; k++) begin : g_src
      logic sc = 1'b0;
      always #(3 + k) sc = ~sc;
      assign src_clk[k] = sc;
   end

   refclk_gen u_refclk_gen (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .src_clk(src_clk), .dbg_mode(dbg),
      .idle_mode(idle), .sleep_mode(sleep), .refclk_out(refclk_out),
      .refclk_oe(refclk_oe));

   always @(posedge refclk_out) edges++;
   always @(refclk_out) if (mon_en) begin
      if (mon_n > 0 && ($time - last_t) < min_w) min_w = $time - last_t;
      last_t = $time;
      mon_n++;
   end

   function automatic longint tsrc(int sel);
      return 6 + 2 * sel;
   endfunction

   function automatic longint exp_per(int d, int sel);
      return (d == 0) ? tsrc(sel) : 2 * d * tsrc(sel);
   endfunction

   // fl = {frz, sidl, oe, rslp}
   function automatic logic [31:0] mk(int d, bit on, logic [3:0] fl, int sel);
      return {1'b0, 15'(d), on, fl, 7'b0, 4'(sel)};
   endfunction

   task automatic chk(bit ok, string tag, longint act, longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(logic [31:0] v);
      @(negedge clk); reg_we = 1'b1; reg_wdata = v;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(output logic [31:0] v);
      @(negedge clk); v = reg_rdata;
   endtask

   task automatic wait_act(bit val);
      logic [31:0] v;
      for (int i = 0; i < 30000; i++) begin
         rd(v);
         if (v[8] == val) break;
      end
      chk(v[8] == val, "R7 active status", v[8], val);
   endtask

   task automatic wait_sw();
      logic [31:0] v;
      for (int i = 0; i < 30000; i++) begin
         rd(v);
         if (!v[9]) break;
      end
      chk(!v[9], "R8 switch flag clears", v[9], 0);
   endtask

   task automatic measure(output longint per, output longint hi);
      longint t0, t1;
      @(posedge refclk_out); t0 = $time;
      @(negedge refclk_out); t1 = $time;
      @(posedge refclk_out); per = $time - t0;
      hi = t1 - t0;
   endtask

   task automatic cnt_edges(output int n);
      repeat (20) @(negedge clk);
      n = edges;
      repeat (40) @(negedge clk);
      n = edges - n;
   endtask

   int cur_d = 0, cur_sel = 0;

   task automatic reconf(int d, int sel, logic [3:0] fl);
      wr(mk(cur_d, 1'b0, fl, cur_sel));
      wait_act(1'b0);
      chk(refclk_out == 1'b0, "R7 parked low after disable", refclk_out, 0);
      wr(mk(d, 1'b0, fl, sel));
      wait_sw();
      wr(mk(d, 1'b1, fl, sel));
      wait_act(1'b1);
      cur_d = d; cur_sel = sel;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      longint per, hi;
      int n;
      void'($urandom(32'd1234));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(v);
      chk(v == 32'h0, "R1 reset readback", v, 0);
      chk(refclk_out == 1'b0, "R1 output low", refclk_out, 0);
      chk(refclk_oe == 1'b0, "R1 oe low", refclk_oe, 0);

      // R13 layout, junk in bits 31,10,7:4 dropped; R12 oe pin
      wr(mk(5, 1'b0, 4'b1111, 2) | 32'h8000_04F0);
      wait_sw();
      rd(v);
      chk(v == mk(5, 1'b0, 4'b1111, 2), "R13 readback layout", v, mk(5, 1'b0, 4'b1111, 2));
      chk(refclk_oe == 1'b1, "R12 oe follows bit 12", refclk_oe, 1);
      wr(mk(5, 1'b0, 4'b0000, 2));
      chk(refclk_oe == 1'b0, "R12 oe cleared", refclk_oe, 0);

      // R2 basic divided period
      wr(mk(5, 1'b1, 4'b0000, 2));
      wait_act(1'b1);
      cur_d = 5; cur_sel = 2;
      measure(per, hi);
      chk(per == 100, "R2 period D=5 src2", per, 100);
      chk(hi == 50, "R2 high phase D=5", hi, 50);

      // R2 R3 R4 random sources and ratios, first one forced to bypass
      for (int it = 0; it < 8; it++) begin
         int d, s;
         d = (it == 0) ? 0 : int'($urandom_range(0, 12));
         s = int'($urandom_range(0, NSRC - 1));
         reconf(d, s, 4'b0000);
         measure(per, hi);
         chk(per == exp_per(d, s), (d == 0) ? "R3 bypass period" : "R2/R4 divided period",
             per, exp_per(d, s));
      end

      // R2 extremes
      reconf(32767, 0, 4'b0000);
      measure(per, hi);
      chk(per == 393204, "R2 max divisor period", per, 393204);
      reconf(1, 8, 4'b0000);
      measure(per, hi);
      chk(per == 44, "R2 divisor 1 period", per, 44);

      // R4 reserved codes
      wr(mk(1, 1'b0, 4'b0000, 8));
      wait_act(1'b0);
      wr(mk(1, 1'b0, 4'b0000, 9));
      rd(v);
      chk(v[3:0] == 4'd8, "R4 reserved code 9 ignored", v[3:0], 8);
      wr(mk(1, 1'b0, 4'b0000, 15));
      rd(v);
      chk(v[3:0] == 4'd8, "R4 reserved code 15 ignored", v[3:0], 8);

      // R5 select locked while active, other fields written
      wr(mk(1, 1'b1, 4'b0000, 8));
      wait_act(1'b1);
      wr(mk(1, 1'b1, 4'b0010, 3));
      rd(v);
      chk(v[3:0] == 4'd8, "R5 select held while active", v[3:0], 8);
      chk(v[12] == 1'b1, "R5 other fields still written", v[12], 1);

      // R6 write ignored while enable != active
      wr(mk(1, 1'b0, 4'b0010, 8));
      wr(mk(1, 1'b0, 4'b0000, 8));
      rd(v);
      chk(v[12] == 1'b1, "R6 write ignored during handoff", v[12], 1);
      wait_act(1'b0);
      chk(refclk_out == 1'b0, "R7 low when off and idle", refclk_out, 0);
      cur_d = 1; cur_sel = 8;

      // R8 R9 live ratio change with a second write while pending
      reconf(4, 1, 4'b0000);
      min_w = 64'd1000000000; mon_n = 0; mon_en = 1'b1;
      wr(mk(9, 1'b1, 4'b0000, 1));
      rd(v);
      chk(v[9] == 1'b1, "R8 switch flag set", v[9], 1);
      wr(mk(3, 1'b1, 4'b0000, 1));
      wait_sw();
      rd(v);
      chk(v[30:16] == 15'd9, "R8 write during switch ignored", v[30:16], 9);
      measure(per, hi);
      chk(per == 144, "R8 new ratio in use", per, 144);
      mon_en = 1'b0;
      chk(min_w >= 32, "R9 no runt during change", min_w, 32);

      // R3 R9 live change into bypass
      min_w = 64'd1000000000; mon_n = 0; mon_en = 1'b1;
      wr(mk(0, 1'b1, 4'b0000, 1));
      wait_sw();
      measure(per, hi);
      mon_en = 1'b0;
      chk(per == 8, "R3 live bypass period", per, 8);
      chk(min_w >= 4, "R9 no runt into bypass", min_w, 4);
      cur_d = 0;

      // R10 sleep
      sleep = 1'b1;
      cnt_edges(n);
      chk(n == 0, "R10 stops in sleep without run bit", n, 0);
      wr(mk(0, 1'b1, 4'b0001, 1));
      cnt_edges(n);
      chk(n == 0, "R10 code 1 stops despite run bit", n, 0);
      reconf(2, 3, 4'b0001);
      cnt_edges(n);
      chk(n > 0, "R10 runs in sleep with run bit", n, 1);
      wr(mk(2, 1'b1, 4'b0000, 3));
      cnt_edges(n);
      chk(n == 0, "R10 stops when run bit cleared", n, 0);
      sleep = 1'b0;
      cnt_edges(n);
      chk(n > 0, "R10 resumes after sleep", n, 1);

      // R11 idle and debug
      idle = 1'b1;
      cnt_edges(n);
      chk(n > 0, "R11 runs in idle without stop bit", n, 1);
      wr(mk(2, 1'b1, 4'b0100, 3));
      cnt_edges(n);
      chk(n == 0, "R11 idle stop", n, 0);
      idle = 1'b0;
      dbg = 1'b1;
      cnt_edges(n);
      chk(n > 0, "R11 runs in debug without freeze bit", n, 1);
      wr(mk(2, 1'b1, 4'b1100, 3));
      cnt_edges(n);
      chk(n == 0, "R11 debug freeze", n, 0);
      dbg = 1'b0;
      cnt_edges(n);
      chk(n > 0, "R11 resumes after debug", n, 1);

      finish_run();
   end
endmodule